// File: doc/BRIEF.md
# Packed PCM Transmit FIFO with Output Slot Mapping

This block is the playback side of one channel of an AC'97 controller. The host pushes 32-bit words into a small FIFO. At the start of every serial frame, the frame engine pulses `frame_req`. The block then walks the output PCM slots that the current channel-count setting enables, one slot per clock, in ascending slot order. For each slot it hands over one 16-bit sample and a valid bit that the frame engine copies into the frame's tag.

Two word formats are supported. In normal mode a word carries one sample in its low half. In compact mode a word carries two samples: the low half goes out first, then the high half. Compact mode packs twice the samples per word, so the FIFO counts as full at half its word depth.

The block reports empty, full, half-empty and busy status. It raises a transmit request when the FIFO is half empty or emptier, and a sticky underrun flag when a slot finds no sample. Dropping the channel enable stops slot filling but keeps the queued words. Only dropping the interface-wide enable discards them.

Top module: `pcm_tx_slot_fifo`

## Requirements
- R1: After a synchronous active-low reset the FIFO is empty with `fifo_empty`=1, `fifo_full`=0, `fifo_half_empty`=1 and `tx_busy`=0, both interrupts are low, and `slot_valid` is 0.
- R2: In normal mode (`compact`=0) each word yields one sample, its bits 15:0. The FIFO is full at DEPTH words (default 16, a multiple of 16). A write while full is dropped.
- R3: In compact mode (`compact`=1) each word yields two samples, bits 15:0 first and then bits 31:16. The FIFO is full at DEPTH/2 words.
- R4: Bit i of `slot_valid`, and lane i of `slot_data` (bits 16*i+15 down to 16*i), stand for slot 3+i. `chan_sel` selects the slots filled as follows:
  - 0 fills slots 3 and 4.
  - 1 fills slots 3, 4, 7 and 8.
  - 2 fills slots 3, 4, 6, 7, 8 and 9.
  - 3 fills no slot.
- R5: A `frame_req` sampled high clears `slot_valid`. From the next clock on, one enabled slot is served per clock, in ascending slot order.
- R6: A slot served while the FIFO is empty keeps its valid bit at 0 and sets the underrun flag. `ur_irq` is the flag gated by `ur_ie`. A clock with `ur_clr` high clears the flag, unless an underrun occurs in that same clock, in which case the flag stays set.
- R7: `fifo_half_empty` is high when twice the word count is at most the full limit of the current mode. `tx_irq` equals `fifo_half_empty` gated by `tx_ie`.
- R8: `tx_busy` is high while the FIFO holds words or slots of the current frame remain to be served.
- R9: With `ch_en`=0, `frame_req` has no effect, no slot is served, and the queued words stay in the FIFO for later frames.
- R10: With `if_en`=0 the FIFO and the pending slots are discarded, and host writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_en | input | 1 | Interface-wide enable; low flushes the FIFO |
| ch_en | input | 1 | Channel enable; low pauses slot filling |
| compact | input | 1 | 1 = two samples per word |
| chan_sel | input | 2 | Channel-count select (slot map) |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| frame_req | input | 1 | Start-of-frame pulse from the frame engine |
| tx_ie | input | 1 | Transmit request interrupt enable |
| ur_ie | input | 1 | Underrun interrupt enable |
| ur_clr | input | 1 | Write-one-to-clear for the underrun flag |
| slot_data | output | 112 | Seven 16-bit lanes, lane i = slot 3+i |
| slot_valid | output | 7 | Per-slot valid tag bits |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO at its mode's word limit |
| fifo_half_empty | output | 1 | FIFO at most half full |
| tx_busy | output | 1 | Data queued or slots still pending |
| tx_irq | output | 1 | Transmit request interrupt |
| ur_irq | output | 1 | Underrun interrupt |

## Verification
The hardest situation to reach is an underrun in the middle of a frame. The FIFO must run dry after some slots of a frame have been served and before the rest are, so that the valid tag comes out partial while the flag is set. The bench sets this up by queueing exactly one normal-mode word before a stereo frame: slot 3 is served and slot 4 starves. The bench then pulses the clear to show that the flag drops. A second hard point is proving that a disabled channel keeps its data. For that, a frame is issued with the channel off, and the same words are then recovered intact in a later frame once the channel is back on.

// File: rtl/ptf_pkg.sv
// Package: shared constants, channel-count codes and the slot map.
// Assumes lane i of the slot outputs stands for output slot 3+i.
package ptf_pkg;
    localparam int NLANE  = 7;
    localparam int SAMP_W = 16;

    typedef enum logic [1:0] {
        CH_STEREO   = 2'd0,
        CH_QUAD     = 2'd1,
        CH_SURROUND = 2'd2,
        CH_NONE     = 2'd3
    } chan_mode_e;

    // Lane mask selected by a channel-count code.
    function automatic logic [NLANE-1:0] lane_map(input logic [1:0] sel);
        case (chan_mode_e'(sel))
            CH_STEREO:   lane_map = 7'b0000011;
            CH_QUAD:     lane_map = 7'b0110011;
            CH_SURROUND: lane_map = 7'b1111011;
            default:     lane_map = 7'b0000000;
        endcase
    endfunction
endpackage

// File: rtl/ptf_fifo.sv
// Module: word FIFO whose full limit halves in compact mode.
// Assumes the reader never pops when empty; flush_n low discards all words.
module ptf_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_n,
    input  logic          compact,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic          half_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_NORM = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_PACK = CW'(DEPTH / 2);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count, cap;
    logic          push_ok, pop_ok;

    assign cap        = compact ? CAP_PACK : CAP_NORM;
    assign full       = (count >= cap);
    assign empty      = (count == '0);
    assign half_empty = ({1'b0, count} << 1) <= {1'b0, cap};
    assign push_ok    = push && !full && flush_n;
    assign pop_ok     = pop && flush_n;
    assign head       = mem[rp];

    // Storage write, no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    // Pointer and occupancy bookkeeping with flush.
    always_ff @(posedge clk) begin
        if (!rst_n || !flush_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP_NORM); // R2
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_n |=> empty); // R10
endmodule

// File: rtl/ptf_slot_seq.sv
// Module: serves the enabled slots of one frame in ascending order.
// Assumes frame_req is a one-cycle pulse; run = interface and channel enabled.
module ptf_slot_seq #(
    parameter int NLANE  = 7,
    parameter int SAMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_n,
    input  logic                    run,
    input  logic                    frame_req,
    input  logic [NLANE-1:0]        lane_mask,
    input  logic                    compact,
    input  logic [2*SAMP_W-1:0]     head,
    input  logic                    fifo_empty,
    output logic                    pop,
    output logic                    starve,
    output logic                    active,
    output logic [NLANE*SAMP_W-1:0] slot_data,
    output logic [NLANE-1:0]        slot_valid
);
    localparam int IW = (NLANE > 1) ? $clog2(NLANE) : 1;

    logic [NLANE-1:0]  pending;
    logic              hi_sel;
    logic [IW-1:0]     cur_idx;
    logic              go, take;
    logic [SAMP_W-1:0] sample;

    // Lowest pending lane is served first.
    always_comb begin
        cur_idx = '0;
        for (int i = NLANE - 1; i >= 0; i--) begin
            if (pending[i]) cur_idx = IW'(i);
        end
    end

    assign go     = run && (pending != '0) && !frame_req;
    assign take   = go && !fifo_empty;
    assign starve = go && fifo_empty;
    assign sample = (compact && hi_sel) ? head[2*SAMP_W-1:SAMP_W] : head[SAMP_W-1:0];
    assign pop    = take && (!compact || hi_sel);
    assign active = (pending != '0);

    // Frame start, per-slot service and half-word selection.
    always_ff @(posedge clk) begin
        if (!rst_n || !flush_n) begin
            pending    <= '0;
            hi_sel     <= 1'b0;
            slot_valid <= '0;
            if (!rst_n) slot_data <= '0;
        end else if (frame_req && run) begin
            pending    <= lane_mask;
            slot_valid <= '0;
        end else if (!run) begin
            pending <= '0;
        end else if (go) begin
            pending[cur_idx] <= 1'b0;
            if (take) begin
                slot_data[cur_idx*SAMP_W +: SAMP_W] <= sample;
                slot_valid[cur_idx] <= 1'b1;
                if (compact) hi_sel <= !hi_sel;
            end
        end
    end

    AST_ONE_SLOT_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_valid & ~$past(slot_valid))); // R5
endmodule

// File: rtl/pcm_tx_slot_fifo.sv
// Module: top of the packed playback FIFO with slot mapping and interrupts.
// Assumes the frame engine pulses frame_req once per frame, at least
// NLANE cycles apart.
module pcm_tx_slot_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    if_en,
    input  logic                                    ch_en,
    input  logic                                    compact,
    input  logic [1:0]                              chan_sel,
    input  logic                                    wr_en,
    input  logic [31:0]                             wr_data,
    input  logic                                    frame_req,
    input  logic                                    tx_ie,
    input  logic                                    ur_ie,
    input  logic                                    ur_clr,
    output logic [ptf_pkg::NLANE*ptf_pkg::SAMP_W-1:0] slot_data,
    output logic [ptf_pkg::NLANE-1:0]               slot_valid,
    output logic                                    fifo_empty,
    output logic                                    fifo_full,
    output logic                                    fifo_half_empty,
    output logic                                    tx_busy,
    output logic                                    tx_irq,
    output logic                                    ur_irq
);
    localparam int WW = 2 * ptf_pkg::SAMP_W;

    logic [WW-1:0] head;
    logic          pop, starve, active, ur_flag;

    ptf_fifo #(.DEPTH(DEPTH), .DW(WW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_n    (if_en),
        .compact    (compact),
        .push       (wr_en),
        .wdata      (wr_data),
        .pop        (pop),
        .head       (head),
        .empty      (fifo_empty),
        .full       (fifo_full),
        .half_empty (fifo_half_empty)
    );

    ptf_slot_seq #(.NLANE(ptf_pkg::NLANE), .SAMP_W(ptf_pkg::SAMP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_n    (if_en),
        .run        (if_en && ch_en),
        .frame_req  (frame_req),
        .lane_mask  (ptf_pkg::lane_map(chan_sel)),
        .compact    (compact),
        .head       (head),
        .fifo_empty (fifo_empty),
        .pop        (pop),
        .starve     (starve),
        .active     (active),
        .slot_data  (slot_data),
        .slot_valid (slot_valid)
    );

    // Sticky underrun flag; a new underrun wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      ur_flag <= 1'b0;
        else if (starve) ur_flag <= 1'b1;
        else if (ur_clr) ur_flag <= 1'b0;
    end

    assign tx_busy = !fifo_empty || active;
    assign tx_irq  = fifo_half_empty && tx_ie;
    assign ur_irq  = ur_flag && ur_ie;

    AST_UR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ur_clr && !starve) |=> !ur_flag); // R6
    AST_UR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        starve |=> ur_flag); // R6
endmodule

// File: tb/tb_pcm_tx_slot_fifo.sv
module tb_pcm_tx_slot_fifo;
    logic         clk = 1'b0;
    logic         rst_n, if_en, ch_en, compact, wr_en, frame_req, tx_ie, ur_ie, ur_clr;
    logic [1:0]   chan_sel;
    logic [31:0]  wr_data;
    logic [111:0] slot_data;
    logic [6:0]   slot_valid;
    logic         fifo_empty, fifo_full, fifo_half_empty, tx_busy, tx_irq, ur_irq;
    int           n_chk = 0, n_bad = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    pcm_tx_slot_fifo dut (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .ch_en(ch_en), .compact(compact),
        .chan_sel(chan_sel), .wr_en(wr_en), .wr_data(wr_data), .frame_req(frame_req),
        .tx_ie(tx_ie), .ur_ie(ur_ie), .ur_clr(ur_clr), .slot_data(slot_data),
        .slot_valid(slot_valid), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .fifo_half_empty(fifo_half_empty), .tx_busy(tx_busy), .tx_irq(tx_irq), .ur_irq(ur_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lane(input int l);
        return slot_data[l*16 +: 16];
    endfunction

    task automatic wr(input logic [31:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic frame();
        frame_req = 1'b1;
        @(negedge clk);
        frame_req = 1'b0;
    endtask

    task automatic flush();
        if_en = 1'b0;
        @(negedge clk);
        if_en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 empty", 32'(fifo_empty), 1);
        chk("R1 full", 32'(fifo_full), 0);
        chk("R1 half", 32'(fifo_half_empty), 1);
        chk("R1 busy", 32'(tx_busy), 0);
        chk("R1 irqs", {30'd0, tx_irq, ur_irq}, 0);
        chk("R1 valid", 32'(slot_valid), 0);
    endtask

    task automatic t_stereo_normal();
        compact = 0; chan_sel = 2'd0;
        wr(32'hAAAA_1111); wr(32'hBBBB_2222);
        chk("R8 busy queued", 32'(tx_busy), 1);
        frame();
        chk("R5 cleared", 32'(slot_valid), 0);
        @(negedge clk);
        chk("R5 first slot", 32'(slot_valid), 7'b0000001);
        chk("R8 busy shifting", 32'(tx_busy), 1);
        @(negedge clk);
        chk("R4 stereo valid", 32'(slot_valid), 7'b0000011);
        chk("R2 lane0", 32'(lane(0)), 16'h1111);
        chk("R2 lane1", 32'(lane(1)), 16'h2222);
        chk("R8 idle", 32'(tx_busy), 0);
    endtask

    task automatic t_quad_compact();
        compact = 1; chan_sel = 2'd1;
        wr(32'h2222_1111); wr(32'h4444_3333);
        frame(); repeat (4) @(negedge clk);
        chk("R4 quad valid", 32'(slot_valid), 7'b0110011);
        chk("R3 lane0", 32'(lane(0)), 16'h1111);
        chk("R3 lane1", 32'(lane(1)), 16'h2222);
        chk("R3 lane4", 32'(lane(4)), 16'h3333);
        chk("R3 lane5", 32'(lane(5)), 16'h4444);
        chk("R3 drained", 32'(fifo_empty), 1);
        compact = 0;
    endtask

    task automatic t_surround();
        compact = 0; chan_sel = 2'd2;
        for (int i = 1; i <= 6; i++) wr(32'(i));
        frame();
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R5 ascending skip slot5", 32'(slot_valid), 7'b0001011);
        chk("R5 slot6 third", 32'(lane(3)), 3);
        repeat (3) @(negedge clk);
        chk("R4 5.1 valid", 32'(slot_valid), 7'b1111011);
        chk("R4 slot7", 32'(lane(4)), 4);
        chk("R4 slot9", 32'(lane(6)), 6);
    endtask

    task automatic t_no_slots();
        chan_sel = 2'd3;
        wr(32'h0000_0077);
        frame(); repeat (2) @(negedge clk);
        chk("R4 code3 valid", 32'(slot_valid), 0);
        chk("R4 code3 kept", 32'(fifo_empty), 0);
        flush();
        chk("R10 flushed", 32'(fifo_empty), 1);
        chk("R10 busy", 32'(tx_busy), 0);
    endtask

    task automatic t_underrun();
        chan_sel = 2'd0; ur_ie = 1;
        wr(32'h0000_5A5A);
        frame(); repeat (2) @(negedge clk);
        chk("R6 partial tag", 32'(slot_valid), 7'b0000001);
        chk("R6 irq set", 32'(ur_irq), 1);
        ur_ie = 0;
        @(negedge clk);
        chk("R6 gated", 32'(ur_irq), 0);
        ur_ie = 1;
        ur_clr = 1; @(negedge clk); ur_clr = 0;
        chk("R6 cleared", 32'(ur_irq), 0);
    endtask

    task automatic t_fill_normal();
        compact = 0; chan_sel = 2'd0; tx_ie = 1;
        for (int i = 1; i <= 8; i++) wr(32'(i));
        chk("R7 half at 8", 32'(tx_irq), 1);
        wr(32'd9);
        chk("R7 not half at 9", 32'(fifo_half_empty), 0);
        for (int i = 10; i <= 16; i++) wr(32'(i));
        chk("R2 full at 16", 32'(fifo_full), 1);
        wr(32'hDEAD);
        for (int f = 0; f < 8; f++) begin
            frame(); repeat (2) @(negedge clk);
        end
        chk("R2 last lane0", 32'(lane(0)), 15);
        chk("R2 last lane1", 32'(lane(1)), 16);
        chk("R2 write dropped", 32'(fifo_empty), 1);
    endtask

    task automatic t_fill_compact();
        compact = 1;
        for (int i = 1; i <= 4; i++) wr(32'(i));
        chk("R7 compact half at 4", 32'(fifo_half_empty), 1);
        wr(32'd5);
        chk("R7 compact not half", 32'(fifo_half_empty), 0);
        for (int i = 6; i <= 8; i++) wr(32'(i));
        chk("R3 full at 8", 32'(fifo_full), 1);
        flush();
        compact = 0;
    endtask

    task automatic t_chan_off();
        chan_sel = 2'd0; ch_en = 0;
        wr(32'h0000_0C01); wr(32'h0000_0C02);
        frame(); repeat (2) @(negedge clk);
        chk("R9 no slots", 32'(slot_valid), 0);
        chk("R9 data kept", 32'(fifo_empty), 0);
        chk("R8 busy while held", 32'(tx_busy), 1);
        ch_en = 1;
        frame(); repeat (2) @(negedge clk);
        chk("R9 resumed lane0", 32'(lane(0)), 16'h0C01);
        chk("R9 resumed lane1", 32'(lane(1)), 16'h0C02);
    endtask

    task automatic t_iface_off();
        wr(32'd1); wr(32'd2); wr(32'd3);
        if_en = 0;
        @(negedge clk);
        wr(32'd4);
        chk("R10 write ignored", 32'(fifo_empty), 1);
        if_en = 1;
        @(negedge clk);
        chk("R10 still empty", 32'(fifo_empty), 1);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        rst_n = 0; if_en = 1; ch_en = 1; compact = 0; chan_sel = 0; wr_en = 0;
        wr_data = 0; frame_req = 0; tx_ie = 0; ur_ie = 0; ur_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_stereo_normal();
        t_quad_compact();
        t_surround();
        t_no_slots();
        t_underrun();
        t_fill_normal();
        t_fill_compact();
        t_chan_off();
        t_iface_off();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end
endmodule